// File: doc/BRIEF.md
# Dual-Lane Rounding Accumulator with Halfword Packing

This block finishes a two-lane fixed-point multiply-accumulate step. It receives two signed 32-bit products packed in one 64-bit word and two signed 32-bit accumulator values. For each lane it adds the product, the accumulator and a half-unit rounding constant of 0x8000. It can clamp each lane to the signed 32-bit range. It then keeps the upper 16 bits of each lane, which rounds the sum to the nearest halfword, and packs the two halves into one 32-bit result.

Each operation also yields an overflow flag and an advance-overflow flag. Both are taken from the sums before any clamping. Sticky copies of the two flags collect every flag raised since reset. In packed-accumulator mode, a single 32-bit register supplies both lane accumulators, with each of its halfwords placed at the top of one lane. The products are formed upstream. Results appear one clock after a valid strobe and are held until the next one.

Top module: `rnd_pack_acc`

## Requirements
- R1: While reset is high and on the first cycle after it, `res`, `ovf`, `adv`, `ovf_sticky`, `adv_sticky` and `out_valid` are all zero.
- R2: Lane 0 uses `prod[31:0]` and lane 1 uses `prod[63:32]`. Each lane sum is the sign-extended accumulator plus the sign-extended product plus 0x8000, computed without wrap.
- R3: `res[31:16]` is bits [31:16] of the lane 1 result and `res[15:0]` is bits [31:16] of the lane 0 result.
- R4: With `sat_en`=1, a lane sum above 0x7FFFFFFF is replaced by 0x7FFFFFFF and one below -0x80000000 by 0x80000000, each lane on its own.
- R5: With `sat_en`=0, each lane result is the low 32 bits of its sum, even when the sum is out of range.
- R6: `ovf` is 1 when either lane sum lies outside the signed 32-bit range, whatever `sat_en` is.
- R7: `adv` is the OR over both lanes of bit 31 XOR bit 30 of the unclamped lane sum.
- R8: With `pk_mode`=1, the lane 0 accumulator is `acc_lo` shifted left by 16 and the lane 1 accumulator is `acc_lo` AND 0xFFFF0000. `acc_hi` has no effect.
- R9: `ovf_sticky` and `adv_sticky` are set by the OR of their old value with the new `ovf` and `adv` on each valid operation. They are cleared only by reset.
- R10: `res`, `ovf`, `adv` and the sticky flags are updated one clock after `in_valid`. `out_valid` pulses in that same cycle. Without `in_valid`, all of them hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| sat_en | input | 1 | Clamp each lane to the signed 32-bit range |
| pk_mode | input | 1 | Derive both accumulators from `acc_lo` |
| prod | input | 64 | Lane 1 product [63:32], lane 0 product [31:0] |
| acc_lo | input | 32 | Lane 0 accumulator, or the packed register |
| acc_hi | input | 32 | Lane 1 accumulator when not packed |
| out_valid | output | 1 | Result updated this cycle |
| res | output | 32 | Packed rounded high halves |
| ovf | output | 1 | Overflow of the last operation |
| adv | output | 1 | Advance overflow of the last operation |
| ovf_sticky | output | 1 | Accumulated overflow |
| adv_sticky | output | 1 | Accumulated advance overflow |

## Verification
Two products just below and at the 0x8000 boundary show whether the rounding constant is added. Operands with different values in each lane show whether the lanes are swapped or the halves are packed in the wrong order. Sums just past the positive and the negative limit are applied in only one lane at a time, with and without clamping, so that clamping and overflow can be seen separately. A value in the 0x40000000 region raises only the advance flag. Packed-mode vectors carry a nonzero `acc_hi` that must have no effect. Idle gaps and a few hundred random vectors complete the run, and during the gaps the results and the sticky flags must hold.

// File: rtl/rnd_pack_acc_pkg.sv
package rnd_pack_acc_pkg;
  typedef struct packed {
    logic ovf;
    logic adv;
  } rac_flags_t;
endpackage

// File: rtl/rac_acc_select.sv
module rac_acc_select #(
  parameter int W = 32
) (
  input  logic         pk_mode,
  input  logic [W-1:0] acc_lo,
  input  logic [W-1:0] acc_hi,
  output logic [W-1:0] lane0_acc,
  output logic [W-1:0] lane1_acc
);
  localparam int HW = W / 2;

  always_comb begin
    if (pk_mode) begin
      lane0_acc = {acc_lo[HW-1:0], {HW{1'b0}}};
      lane1_acc = {acc_lo[W-1:HW], {HW{1'b0}}};
    end else begin
      lane0_acc = acc_lo;
      lane1_acc = acc_hi;
    end
  end
endmodule

// File: rtl/rac_lane.sv
module rac_lane #(
  parameter int W = 32
) (
  input  logic         sat_en,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] prod,
  output logic [W-1:0] lane_res,
  output logic         lane_ovf,
  output logic         lane_adv
);
  localparam int EW = W + 2;
  localparam int HW = W / 2;
  localparam logic [EW-1:0] RND = EW'(1) << (HW - 1);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic [EW-1:0] sum;
  logic [2:0]    top3;

  assign sum  = {{2{acc[W-1]}}, acc} + {{2{prod[W-1]}}, prod} + RND;
  assign top3 = sum[EW-1:W-1];

  always_comb begin
    lane_ovf = !((top3 == 3'b000) || (top3 == 3'b111));
    lane_adv = sum[W-1] ^ sum[W-2];
    if (sat_en && lane_ovf)
      lane_res = sum[EW-1] ? MINV : MAXV;
    else
      lane_res = sum[W-1:0];
  end
endmodule

// File: rtl/rac_flag_accum.sv
module rac_flag_accum
  import rnd_pack_acc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       upd,
  input  rac_flags_t fresh,
  output rac_flags_t sticky
);
  always_ff @(posedge clk) begin
    if (rst)
      sticky <= '0;
    else if (upd)
      sticky <= sticky | fresh;
  end
endmodule

// File: rtl/rnd_pack_acc.sv
module rnd_pack_acc
  import rnd_pack_acc_pkg::*;
#(
  parameter int LANE_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                sat_en,
  input  logic                pk_mode,
  input  logic [2*LANE_W-1:0] prod,
  input  logic [LANE_W-1:0]   acc_lo,
  input  logic [LANE_W-1:0]   acc_hi,
  output logic                out_valid,
  output logic [LANE_W-1:0]   res,
  output logic                ovf,
  output logic                adv,
  output logic                ovf_sticky,
  output logic                adv_sticky
);
  localparam int LANES = 2;
  localparam int HW    = LANE_W / 2;

  logic [LANE_W-1:0] acc_sel [LANES];
  logic [LANE_W-1:0] lres    [LANES];
  logic [LANES-1:0]  l_ovf, l_adv;
  logic [LANE_W-1:0] pack_d;
  rac_flags_t        fresh, sticky;

  rac_acc_select #(.W(LANE_W)) u_sel (
    .pk_mode   (pk_mode),
    .acc_lo    (acc_lo),
    .acc_hi    (acc_hi),
    .lane0_acc (acc_sel[0]),
    .lane1_acc (acc_sel[1])
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    rac_lane #(.W(LANE_W)) u_lane (
      .sat_en   (sat_en),
      .acc      (acc_sel[i]),
      .prod     (prod[i*LANE_W +: LANE_W]),
      .lane_res (lres[i]),
      .lane_ovf (l_ovf[i]),
      .lane_adv (l_adv[i])
    );
    assign pack_d[i*HW +: HW] = lres[i][LANE_W-1 -: HW];

    AST_SAT_CLAMP: assert property (@(posedge clk) disable iff (rst)
      (in_valid && sat_en && l_ovf[i]) |=>
        (res[i*HW +: HW] == {1'b0, {(HW-1){1'b1}}} ||
         res[i*HW +: HW] == {1'b1, {(HW-1){1'b0}}})); // R4
  end

  assign fresh.ovf = |l_ovf;
  assign fresh.adv = |l_adv;

  rac_flag_accum u_flags (
    .clk    (clk),
    .rst    (rst),
    .upd    (in_valid),
    .fresh  (fresh),
    .sticky (sticky)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res       <= '0;
      ovf       <= 1'b0;
      adv       <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res <= pack_d;
        ovf <= fresh.ovf;
        adv <= fresh.adv;
      end
    end
  end

  assign ovf_sticky = sticky.ovf;
  assign adv_sticky = sticky.adv;

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R10
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(res) && $stable(ovf) && $stable(adv) && !out_valid)); // R10
  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (rst)
    !$fell(ovf_sticky) && !$fell(adv_sticky)); // R9
  AST_STICKY_COVER: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((!ovf || ovf_sticky) && (!adv || adv_sticky))); // R9
endmodule

// File: tb/tb_rnd_pack_acc.sv
module tb_rnd_pack_acc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, sat_en = 1'b0, pk_mode = 1'b0;
  logic [63:0] prod = '0;
  logic [31:0] acc_lo = '0, acc_hi = '0;
  logic        out_valid, ovf, adv, ovf_sticky, adv_sticky;
  logic [31:0] res;

  typedef struct {
    logic [31:0] res;
    logic        ovf, adv, sov, sadv;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t last;
  logic have_last = 1'b0;
  int   total = 0, bad = 0;
  logic m_sov = 1'b0, m_sadv = 1'b0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  rnd_pack_acc dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .sat_en(sat_en),
    .pk_mode(pk_mode), .prod(prod), .acc_lo(acc_lo), .acc_hi(acc_hi),
    .out_valid(out_valid), .res(res), .ovf(ovf), .adv(adv),
    .ovf_sticky(ovf_sticky), .adv_sticky(adv_sticky)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic void lane_model(input logic [31:0] a, input logic [31:0] p,
      input logic s, output logic [31:0] r, output logic o, output logic v);
    longint sum = longint'($signed(a)) + longint'($signed(p)) + 64'sd32768;
    o = (sum > 64'sd2147483647) || (sum < -64'sd2147483648);
    v = sum[31] ^ sum[30];
    if (s && o) r = (sum < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
    else r = sum[31:0];
  endfunction

  task automatic drive(input logic s, input logic pk, input logic [63:0] p,
                       input logic [31:0] al, input logic [31:0] ah, input string tag);
    exp_t e;
    logic [31:0] a0, a1, r0, r1;
    logic o0, o1, v0, v1;
    a0 = pk ? {al[15:0], 16'h0} : al;   // R8
    a1 = pk ? {al[31:16], 16'h0} : ah;  // R8
    lane_model(a0, p[31:0], s, r0, o0, v0);
    lane_model(a1, p[63:32], s, r1, o1, v1);
    e.res = {r1[31:16], r0[31:16]};
    e.ovf = o0 | o1;
    e.adv = v0 | v1;
    m_sov  = m_sov | e.ovf;
    m_sadv = m_sadv | e.adv;
    e.sov = m_sov;
    e.sadv = m_sadv;
    e.tag = tag;
    @(negedge clk);
    sat_en = s; pk_mode = pk; prod = p; acc_lo = al; acc_hi = ah; in_valid = 1'b1;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      prod = {$urandom, $urandom}; acc_lo = $urandom; acc_hi = $urandom;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        exp_t e;
        if (q.size() == 0) begin
          chk(1'b0, "R10 unexpected out_valid", 32'(out_valid), 32'h0);
        end else begin
          e = q.pop_front();
          chk(res === e.res, e.tag, res, e.res);
          chk(ovf === e.ovf, "R6 ovf", 32'(ovf), 32'(e.ovf));
          chk(adv === e.adv, "R7 adv", 32'(adv), 32'(e.adv));
          chk(ovf_sticky === e.sov, "R9 ovf_sticky", 32'(ovf_sticky), 32'(e.sov));
          chk(adv_sticky === e.sadv, "R9 adv_sticky", 32'(adv_sticky), 32'(e.sadv));
          last = e;
          have_last = 1'b1;
        end
      end else if (have_last) begin
        chk(res === last.res, "R10 hold res", res, last.res);
        chk(ovf_sticky === last.sov && adv_sticky === last.sadv, "R10 hold sticky",
            {30'h0, ovf_sticky, adv_sticky}, {30'h0, last.sov, last.sadv});
      end
    end
  end

  initial begin
    repeat (500000) @(posedge clk);
    $display("FAIL watchdog R10 actual=%h expected=%h", 32'd0, 32'd1);
    total++; bad++;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({res, out_valid, ovf, adv, ovf_sticky, adv_sticky} === '0, "R1 in reset",
        res, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk({res, out_valid, ovf, adv, ovf_sticky, adv_sticky} === '0, "R1 after reset",
        {27'h0, out_valid, ovf, adv, ovf_sticky, adv_sticky}, 32'h0);

    drive(0, 0, {32'h0002_0000, 32'h0001_2345}, 32'h0001_0000, 32'h0003_0000, "R2 basic");
    drive(0, 0, {32'h0000_8000, 32'h0000_7FFF}, 32'h0, 32'h0, "R2 rounding edge");
    drive(1, 0, {32'hFFFF_8000, 32'hFFFF_7FFF}, 32'h0, 32'h0, "R2 negative rounding");
    drive(0, 0, {32'h1234_0000, 32'h0000_0000}, 32'h0000_0000, 32'h0000_5678, "R3 lane order");
    drive(0, 0, {32'h0, 32'h0BCD_0000}, 32'h0000_0000, 32'h0A00_0000, "R3 packing");
    idle(2);
    drive(0, 0, {32'h0, 32'h4000_0000}, 32'h0, 32'h0, "R7 adv only");
    drive(1, 0, {32'h0001_0000, 32'h0000_1000}, 32'h0000_0000, 32'h7FFF_0000, "R4 pos clamp lane1");
    drive(1, 0, {32'h0000_0000, 32'h8000_0000}, 32'h8000_0000, 32'h0000_1000, "R4 neg clamp lane0");
    drive(0, 0, {32'h0001_0000, 32'h0000_1000}, 32'h0000_0000, 32'h7FFF_0000, "R5 wrap lane1");
    drive(0, 0, {32'h0000_0000, 32'h8000_0000}, 32'h8000_0000, 32'h0000_1000, "R5 wrap lane0");
    drive(1, 0, {32'h7FFF_FFFF, 32'h8000_0000}, 32'h8000_0000, 32'h7FFF_FFFF, "R4 both lanes");
    idle(3);
    drive(0, 1, {32'h0000_1000, 32'h0000_2000}, 32'hABCD_1234, 32'hDEAD_BEEF, "R8 packed");
    drive(0, 1, {32'h0000_1000, 32'h0000_2000}, 32'hABCD_1234, 32'h0000_0000, "R8 acc_hi ignored");
    drive(1, 1, {32'h8000_0000, 32'h7FFF_0000}, 32'h8000_7FFF, 32'h1234_5678, "R8 packed sat");
    for (int i = 0; i < 300; i++) begin
      logic [1:0] sh;
      sh = 2'($urandom);
      drive(1'($urandom), 1'($urandom), {$urandom, $urandom} >> sh,
            $urandom, $urandom, "R2 random");
      if ((i % 17) == 0) idle(1);
    end
    idle(3);
    done = 1'b1;
    chk(q.size() == 0, "R10 drained", 32'(q.size()), 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule